// File: doc/BRIEF.md
# Packed Saturating Adder with Selectable Element Width

This block adds two 64-bit words as a packed vector of integer elements. An element-width input picks the lane size: 8, 16, 32 or 64 bits. The lanes are fully independent, so no carry crosses a lane boundary. Each lane can run a plain add or an add-with-carry that takes its own carry-in bit. The carry-out is taken at the lane's own top bit plus one.

The exact sum of each lane is formed with two guard bits, so it behaves as if it had unlimited precision. It can then be clamped to the signed range of the lane, clamped to the unsigned range, or left to wrap. Each lane also produces a 4-bit condition field. The field compares the lane result with zero and carries an overflow bit that describes only the current operation.

Condition field i belongs to element i. Per-lane write enables for the condition fields and per-byte write enables for the result let a register file with byte granularity write only the active elements. All outputs are registered one clock after an operation is presented.

Top module: `ewsat_simd_add`

## Requirements
- R1: `elem_width` selects the lane size: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. The number of lanes is 64 divided by the lane size. Element i occupies result bits [i*W +: W]. No carry propagates between lanes, and without saturation each lane result is the sum modulo 2^W.
- R2: `carry_out[i]` is bit W of the unsigned sum a_i + b_i + c_i of lane i, where c_i is the effective carry-in. That is bit 8 for 8-bit lanes. Slots i at or above the lane count report a carry of 0 and a condition field of 0.
- R3: When `use_carry` is 0, `carry_in` has no effect on the result, the carry-out or the condition fields. When it is 1, `carry_in[i]` is added into lane i.
- R4: The exact lane sum uses two's-complement operands when `op_signed` is 1 and zero-extended operands otherwise. With `sat_mode` = 1 (signed clamp), a sum above 2^(W-1)-1 gives 2^(W-1)-1 and a sum below -2^(W-1) gives -2^(W-1).
- R5: With `sat_mode` = 2 (unsigned clamp), a negative exact sum gives 0, including a signed add whose true result is negative. A sum above 2^W-1 gives all ones.
- R6: With `sat_mode` 0 or 3 the result wraps. The overflow bit flags an exact sum outside the signed lane range when `op_signed` is 1, and outside the unsigned range otherwise. Under a clamp mode, the overflow bit flags a sum outside the clamp range.
- R7: The overflow bit is not sticky. Each operation sets it only from its own exact sum, so a clean operation after an overflowing one reports 0.
- R8: Field i sits at `cond_fields[4*i +: 4]`. Bit 3 is less-than, bit 2 is greater-than, bit 1 is equal and bit 0 is overflow. Less-than, greater-than and equal compare the final lane result, read as signed, against zero.
- R9: `cond_we[i]` is 1 exactly when the operation is valid, `rc_en` is 1, `lane_mask[i]` is 1 and lane i exists at the selected width.
- R10: `byte_we[j]` is 1 exactly when the operation is valid and the lane covering byte j has its `lane_mask` bit set. For example, element 3 at 16 bits enables only bytes 6 and 7. Mask bits at or above the lane count are ignored, and an idle cycle enables nothing.
- R11: Outputs change one clock edge after `op_valid` is presented. `result`, `carry_out` and `cond_fields` hold during idle cycles. Reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| elem_width | input | 2 | Lane size select (8/16/32/64) |
| op_signed | input | 1 | Operands are two's-complement |
| sat_mode | input | 2 | 0 wrap, 1 signed clamp, 2 unsigned clamp, 3 wrap |
| use_carry | input | 1 | Add-with-carry when 1 |
| rc_en | input | 1 | Write condition fields |
| lane_mask | input | 8 | Per-element enable, bit i for element i |
| carry_in | input | 8 | Per-element carry-in, bit i for element i |
| src_a | input | 64 | First operand word |
| src_b | input | 64 | Second operand word |
| result | output | 64 | Packed lane results |
| carry_out | output | 8 | Per-element carry-out |
| cond_fields | output | 32 | Per-element condition fields |
| cond_we | output | 8 | Per-element condition field write enable |
| byte_we | output | 8 | Per-byte result write enable |

## Verification
Directed words place all-ones lanes next to a carry-in, so that a carry that leaks across a lane boundary shows up as a wrong neighbour lane at every width. Pairs at the signed and unsigned range limits are run under each clamp mode, and a signed negative sum is run under the unsigned clamp; these tell the signed bounds apart from the unsigned ones. A single mask bit, out-of-range mask bits, a cleared `rc_en` and `carry_in` with carry disabled show whether the enables and the carry gating track lane index and width. A run of seeded vectors across all modes then compares every lane with an unlimited-precision model.

// File: rtl/ewsat_pkg.sv
package ewsat_pkg;

  typedef enum logic [1:0] {
    SAT_NONE     = 2'd0,
    SAT_SIGNED   = 2'd1,
    SAT_UNSIGNED = 2'd2,
    SAT_RSVD     = 2'd3
  } sat_mode_e;

  // Condition field layout: {lt, gt, eq, ovf}
  function automatic logic [3:0] make_cond(input logic res_neg,
                                           input logic res_zero,
                                           input logic ovf);
    logic lt, gt, eq;
    lt = res_neg;
    eq = res_zero;
    gt = !res_neg && !res_zero;
    return {lt, gt, eq, ovf};
  endfunction

  // True when the wrap/overflow range is the signed one
  function automatic logic signed_range(input sat_mode_e sm, input logic op_signed);
    return (sm == SAT_SIGNED) || ((sm != SAT_UNSIGNED) && op_signed);
  endfunction

endpackage

// File: rtl/ewsat_lane.sv
module ewsat_lane
  import ewsat_pkg::*;
#(
  parameter int EW = 8
) (
  input  logic [EW-1:0] a,
  input  logic [EW-1:0] b,
  input  logic          cin,
  input  logic          use_carry,
  input  logic          op_signed,
  input  sat_mode_e     sat,
  output logic [EW-1:0] res,
  output logic          cout,
  output logic [3:0]    cond
);
  localparam int XW = EW + 2;
  localparam logic [XW-1:0] SMAX = {3'b000, {(EW-1){1'b1}}};
  localparam logic [XW-1:0] SMIN = {3'b111, {(EW-1){1'b0}}};
  localparam logic [XW-1:0] UMAX = {2'b00, {EW{1'b1}}};

  logic          cin_eff;
  logic [XW-1:0] xa, xb, exact;
  logic [EW:0]   raw;
  logic          above_s, below_s, above_u, below_u, ovf;

  assign cin_eff = use_carry & cin;
  assign xa      = op_signed ? {{2{a[EW-1]}}, a} : {2'b00, a};
  assign xb      = op_signed ? {{2{b[EW-1]}}, b} : {2'b00, b};
  assign exact   = xa + xb + {{(XW-1){1'b0}}, cin_eff};
  assign raw     = {1'b0, a} + {1'b0, b} + {{EW{1'b0}}, cin_eff};
  assign cout    = raw[EW];

  assign above_s = $signed(exact) > $signed(SMAX);
  assign below_s = $signed(exact) < $signed(SMIN);
  assign below_u = exact[XW-1];
  assign above_u = !exact[XW-1] && (exact > UMAX);
  assign ovf     = signed_range(sat, op_signed) ? (above_s | below_s)
                                                : (above_u | below_u);

  always_comb begin
    res = exact[EW-1:0];
    unique case (sat)
      SAT_SIGNED: begin
        if (above_s)      res = SMAX[EW-1:0];
        else if (below_s) res = SMIN[EW-1:0];
      end
      SAT_UNSIGNED: begin
        if (below_u)      res = '0;
        else if (above_u) res = '1;
      end
      default: res = exact[EW-1:0];
    endcase
  end

  assign cond = make_cond(res[EW-1], res == '0, ovf);
endmodule

// File: rtl/ewsat_bank.sv
module ewsat_bank
  import ewsat_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int EW     = 8,
  parameter int NSLOT  = 8
) (
  input  logic [DATA_W-1:0]  a,
  input  logic [DATA_W-1:0]  b,
  input  logic [NSLOT-1:0]   cin,
  input  logic               use_carry,
  input  logic               op_signed,
  input  sat_mode_e          sat,
  output logic [DATA_W-1:0]  res,
  output logic [NSLOT-1:0]   cout,
  output logic [4*NSLOT-1:0] cond
);
  localparam int NL = DATA_W / EW;

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    if (k < NL) begin : g_lane
      ewsat_lane #(.EW(EW)) u_lane (
        .a        (a[k*EW +: EW]),
        .b        (b[k*EW +: EW]),
        .cin      (cin[k]),
        .use_carry(use_carry),
        .op_signed(op_signed),
        .sat      (sat),
        .res      (res[k*EW +: EW]),
        .cout     (cout[k]),
        .cond     (cond[4*k +: 4])
      );
    end else begin : g_empty
      assign cout[k]       = 1'b0;
      assign cond[4*k +: 4] = 4'b0000;
    end
  end
endmodule

// File: rtl/ewsat_wren.sv
module ewsat_wren #(
  parameter int DATA_W = 64,
  parameter int MIN_EW = 8,
  parameter int NSLOT  = DATA_W / MIN_EW,
  parameter int NBYTE  = DATA_W / 8,
  parameter int SEL_W  = 2
) (
  input  logic             valid,
  input  logic             rc_en,
  input  logic [SEL_W-1:0] elem_width,
  input  logic [NSLOT-1:0] lane_mask,
  output logic [NBYTE-1:0] byte_we,
  output logic [NSLOT-1:0] cond_we
);
  localparam int BPS = MIN_EW / 8;

  int lanes;
  assign lanes = NSLOT >> elem_width;

  always_comb begin
    for (int j = 0; j < NBYTE; j++) begin
      byte_we[j] = valid && lane_mask[(j / BPS) >> elem_width];
    end
    for (int i = 0; i < NSLOT; i++) begin
      cond_we[i] = valid && rc_en && lane_mask[i] && (i < lanes);
    end
  end
endmodule

// File: rtl/ewsat_simd_add.sv
module ewsat_simd_add
  import ewsat_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int MIN_EW = 8,
  localparam int NSLOT = DATA_W / MIN_EW,
  localparam int NBYTE = DATA_W / 8,
  localparam int NWID  = $clog2(NSLOT) + 1,
  localparam int SEL_W = $clog2(NWID)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_valid,
  input  logic [SEL_W-1:0]   elem_width,
  input  logic               op_signed,
  input  logic [1:0]         sat_mode,
  input  logic               use_carry,
  input  logic               rc_en,
  input  logic [NSLOT-1:0]   lane_mask,
  input  logic [NSLOT-1:0]   carry_in,
  input  logic [DATA_W-1:0]  src_a,
  input  logic [DATA_W-1:0]  src_b,
  output logic [DATA_W-1:0]  result,
  output logic [NSLOT-1:0]   carry_out,
  output logic [4*NSLOT-1:0] cond_fields,
  output logic [NSLOT-1:0]   cond_we,
  output logic [NBYTE-1:0]   byte_we
);
  sat_mode_e          sat;
  logic [DATA_W-1:0]  bank_res  [NWID];
  logic [NSLOT-1:0]   bank_cout [NWID];
  logic [4*NSLOT-1:0] bank_cond [NWID];
  logic [NBYTE-1:0]   be_d;
  logic [NSLOT-1:0]   cwe_d;
  logic [SEL_W-1:0]   ew_q;

  assign sat = sat_mode_e'(sat_mode);

  for (genvar g = 0; g < NWID; g++) begin : g_width
    ewsat_bank #(.DATA_W(DATA_W), .EW(MIN_EW << g), .NSLOT(NSLOT)) u_bank (
      .a        (src_a),
      .b        (src_b),
      .cin      (carry_in),
      .use_carry(use_carry),
      .op_signed(op_signed),
      .sat      (sat),
      .res      (bank_res[g]),
      .cout     (bank_cout[g]),
      .cond     (bank_cond[g])
    );
  end

  ewsat_wren #(.DATA_W(DATA_W), .MIN_EW(MIN_EW), .NSLOT(NSLOT), .NBYTE(NBYTE),
               .SEL_W(SEL_W)) u_wren (
    .valid     (op_valid),
    .rc_en     (rc_en),
    .elem_width(elem_width),
    .lane_mask (lane_mask),
    .byte_we   (be_d),
    .cond_we   (cwe_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result      <= '0;
      carry_out   <= '0;
      cond_fields <= '0;
      cond_we     <= '0;
      byte_we     <= '0;
      ew_q        <= '0;
    end else begin
      byte_we <= be_d;
      cond_we <= cwe_d;
      if (op_valid) begin
        result      <= bank_res[elem_width];
        carry_out   <= bank_cout[elem_width];
        cond_fields <= bank_cond[elem_width];
        ew_q        <= elem_width;
      end
    end
  end

  // R10, R11: an idle cycle enables no write
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (byte_we == '0) && (cond_we == '0));

  // R9: condition fields are not written without rc_en
  p_rc_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !rc_en) |=> (cond_we == '0));

  for (genvar i = 0; i < NSLOT; i++) begin : g_chk_slot
    // R8: a written field has exactly one of lt/gt/eq set
    p_field_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cond_we[i] |-> ($countones(cond_fields[4*i+1 +: 3]) == 1));
    // R2: slots beyond the lane count stay clear
    p_unused_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (i >= (NSLOT >> ew_q)) |-> (!carry_out[i] && (cond_fields[4*i +: 4] == 4'b0000)));
  end

  for (genvar k = 0; k < NBYTE / 2; k++) begin : g_chk_pair
    // R10: at 16-bit lanes bytes are enabled in pairs
    p_be_pairs_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(op_valid) && ($past(elem_width) == SEL_W'(1))) |->
        (byte_we[2*k] == byte_we[2*k+1]));
  end
endmodule

// File: tb/ewsat_simd_add_tb_top.sv
module ewsat_simd_add_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [1:0]  elem_width = '0;
  logic        op_signed = 1'b0;
  logic [1:0]  sat_mode = '0;
  logic        use_carry = 1'b0;
  logic        rc_en = 1'b0;
  logic [7:0]  lane_mask = '0;
  logic [7:0]  carry_in = '0;
  logic [63:0] src_a = '0;
  logic [63:0] src_b = '0;
  logic [63:0] result;
  logic [7:0]  carry_out;
  logic [31:0] cond_fields;
  logic [7:0]  cond_we;
  logic [7:0]  byte_we;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  ewsat_simd_add dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .elem_width(elem_width),
    .op_signed(op_signed), .sat_mode(sat_mode), .use_carry(use_carry),
    .rc_en(rc_en), .lane_mask(lane_mask), .carry_in(carry_in),
    .src_a(src_a), .src_b(src_b), .result(result), .carry_out(carry_out),
    .cond_fields(cond_fields), .cond_we(cond_we), .byte_we(byte_we)
  );

  typedef struct {
    logic        chk_data;
    logic [63:0] res;
    logic [7:0]  cout;
    logic [31:0] cond;
    logic [7:0]  cwe;
    logic [7:0]  be;
    string       tag;
  } exp_t;

  exp_t sb_q[$];

  function automatic exp_t model(input logic v, input logic [1:0] ew, input logic sg,
                                 input logic [1:0] sm, input logic uc, input logic rc,
                                 input logic [7:0] mk, input logic [7:0] ci,
                                 input logic [63:0] a, input logic [63:0] b,
                                 input string tag);
    exp_t e;
    int w = 8 << ew;
    int n = 8 >> ew;
    logic [71:0] lmask = (72'd1 << w) - 72'd1;
    e.chk_data = v; e.res = '0; e.cout = '0; e.cond = '0; e.cwe = '0; e.be = '0;
    e.tag = tag;
    for (int i = 0; i < n; i++) begin
      logic [71:0] ua, ub, su, c, re;
      logic signed [71:0] sa, sbv, ex, lo, hi, cl;
      logic ov, neg, z, srng;
      ua = ({8'd0, a} >> (i * w)) & lmask;
      ub = ({8'd0, b} >> (i * w)) & lmask;
      c  = {71'd0, uc & ci[i]};
      sa  = (sg && ua[w-1]) ? ua - (72'd1 << w) : ua;
      sbv = (sg && ub[w-1]) ? ub - (72'd1 << w) : ub;
      ex = sa + sbv + c;
      su = ua + ub + c;
      e.cout[i] = su[w];
      srng = (sm == 2'd1) || (sm != 2'd2 && sg);
      if (srng) begin lo = 72'd0 - (72'd1 << (w - 1)); hi = (72'd1 << (w - 1)) - 72'd1; end
      else      begin lo = 72'd0;                       hi = (72'd1 << w) - 72'd1; end
      ov = (ex < lo) || (ex > hi);
      cl = ex;
      if (sm == 2'd1 || sm == 2'd2) begin
        if (ex < lo) cl = lo;
        else if (ex > hi) cl = hi;
      end
      re = cl & lmask;
      e.res = e.res | 64'(re << (i * w));
      neg = re[w-1];
      z = (re == 72'd0);
      e.cond[4*i +: 4] = {neg, !neg && !z, z, ov};
      e.cwe[i] = v && rc && mk[i];
      for (int j = 0; j < w / 8; j++) e.be[i*(w/8) + j] = v && mk[i];
    end
    return e;
  endfunction

  task automatic chk(input string what, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [1:0] ew, input logic sg,
                       input logic [1:0] sm, input logic uc, input logic rc,
                       input logic [7:0] mk, input logic [7:0] ci,
                       input logic [63:0] a, input logic [63:0] b, input string tag);
    @(negedge clk);
    op_valid = v; elem_width = ew; op_signed = sg; sat_mode = sm; use_carry = uc;
    rc_en = rc; lane_mask = mk; carry_in = ci; src_a = a; src_b = b;
    sb_q.push_back(model(v, ew, sg, sm, uc, rc, mk, ci, a, b, tag));
  endtask

  task automatic idle(input string tag);
    drive(1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 8'h00, 8'h00, 64'd0, 64'd0, tag);
  endtask

  // Monitor: one expected item per clock, sampled after the edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        chk("byte_we", e.tag, {56'd0, byte_we}, {56'd0, e.be});
        chk("cond_we", e.tag, {56'd0, cond_we}, {56'd0, e.cwe});
        if (e.chk_data) begin
          chk("result", e.tag, result, e.res);
          chk("carry_out", e.tag, {56'd0, carry_out}, {56'd0, e.cout});
          chk("cond_fields", e.tag, {32'd0, cond_fields}, {32'd0, e.cond});
        end
      end
    end
  end

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #23;
    // R11: reset state
    chk("reset result", "R11", result, 64'd0);
    chk("reset flags", "R11", {24'd0, carry_out, cond_we, byte_we}, 64'd0);
    chk("reset cond", "R11", {32'd0, cond_fields}, 64'd0);
    rst_n = 1'b1;
    idle("R11");

    // R1: wrap at 8 bits, no carry leaks into neighbours
    drive(1, 2'd0, 0, 2'd0, 0, 1, 8'hFF, 8'h00, 64'hFF01_80FF_7F00_10FF,
          64'h0101_8001_0100_F001, "R1");
    // R2: add-with-carry at 8 bits, bit 8 is the carry
    drive(1, 2'd0, 0, 2'd0, 1, 1, 8'hFF, 8'hFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, "R2");
    // R3: carry-in ignored without use_carry
    drive(1, 2'd0, 0, 2'd0, 0, 1, 8'hFF, 8'hFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, "R3");
    drive(1, 2'd1, 0, 2'd0, 1, 1, 8'hFF, 8'h05, 64'h0000_FFFF_1234_FFFF, 64'h0000_0000_0001_0000, "R3");
    // R4: signed clamp at 16 bits, both bounds; unsigned operands above signed max
    drive(1, 2'd1, 1, 2'd1, 0, 1, 8'hFF, 8'h00, 64'h7FFF_8000_0005_1234,
          64'h0001_FFFF_FFF0_0001, "R4");
    drive(1, 2'd0, 0, 2'd1, 0, 1, 8'hFF, 8'h00, 64'h0000_0000_0000_00FF, 64'h0000_0000_0000_0001, "R4");
    // R5: unsigned clamp, signed negative sum goes to zero, large sum to all ones
    drive(1, 2'd0, 1, 2'd2, 0, 1, 8'hFF, 8'h00, 64'h0000_0000_0000_0005, 64'h0000_0000_0000_00F0, "R5");
    drive(1, 2'd0, 0, 2'd2, 0, 1, 8'hFF, 8'h00, 64'hF000_0000_0000_00F0, 64'h2000_0000_0000_0020, "R5");
    // R6: wrap with overflow flag, signed and unsigned ranges, 32 and 64 bits
    drive(1, 2'd2, 1, 2'd0, 0, 1, 8'hFF, 8'h00, 64'h7FFF_FFFF_8000_0000, 64'h0000_0001_FFFF_FFFF, "R6");
    drive(1, 2'd3, 0, 2'd3, 1, 1, 8'hFF, 8'h01, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, "R6");
    // R7: overflow then a clean operation on the same lanes
    drive(1, 2'd0, 1, 2'd1, 0, 1, 8'hFF, 8'h00, 64'h7F7F_7F7F_7F7F_7F7F, 64'h0101_0101_0101_0101, "R7");
    drive(1, 2'd0, 1, 2'd1, 0, 1, 8'hFF, 8'h00, 64'h0101_0101_0101_0101, 64'h0101_0101_0101_0101, "R7");
    // R8: lt/gt/eq across negative, positive and zero lanes
    drive(1, 2'd1, 1, 2'd0, 0, 1, 8'hFF, 8'h00, 64'h8000_0005_0000_FFFF, 64'h0000_0001_0000_0001, "R8");
    // R9: rc_en low, and masked lanes
    drive(1, 2'd0, 0, 2'd0, 0, 0, 8'hFF, 8'h00, 64'h1234_5678_9ABC_DEF0, 64'h1111_1111_1111_1111, "R9");
    drive(1, 2'd2, 0, 2'd0, 0, 1, 8'h02, 8'h00, 64'h1234_5678_9ABC_DEF0, 64'h1, "R9");
    // R10: element 3 at 16 bits, out-of-range mask bits at 64 bits
    drive(1, 2'd1, 0, 2'd0, 0, 1, 8'h08, 8'h00, 64'h1, 64'h2, "R10");
    drive(1, 2'd3, 0, 2'd0, 0, 1, 8'hFE, 8'h00, 64'h1, 64'h2, "R10");
    drive(1, 2'd2, 0, 2'd0, 0, 1, 8'hF1, 8'h00, 64'h1, 64'h2, "R10");
    idle("R10");
    idle("R11");
    // R1, R4, R5, R6: seeded vectors across all modes
    for (int k = 0; k < 60; k++) begin
      logic [63:0] ra, rb;
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      if (k % 4 == 0) rb = ~ra;
      drive(1, 2'($urandom % 4), 1'($urandom), 2'($urandom % 4), 1'($urandom),
            1'($urandom), 8'($urandom), 8'($urandom), ra, rb, "R4_R5_R6");
    end
    idle("R11");
    while (sb_q.size() > 0) begin
      @(posedge clk);
      #3;
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule